// File: doc/BRIEF.md
# EDO DRAM Access Cycle Controller

This block sits between a synchronous host and a 1M x 16 asynchronous DRAM with extended-data-out page mode. It takes one request at a time over a valid/ready handshake. Each request carries a 20-bit word address, a write flag, two byte enables and 16 bits of write data. The block turns that request into the strobe sequence the memory needs. The row half of the address goes out on a 12-line multiplexed bus as the row strobe falls. The column half goes out before the byte column strobes fall. Reads come back on a response port with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row is served as a page-mode column access, with no new row activation. A request to a different row first closes the row and waits out the row precharge. A row that has been open too long is closed even if no request is waiting. Every analog timing minimum is given in nanoseconds and turned into a clock-cycle count by rounding up at the chosen clock period.

The state machine has seven states:
- IDLE: the row strobe is high and no row is open.
- ACTV: the row address is held on the bus.
- CSET: the column address, the write strobe and the write data are set up.
- CACC: the column strobes are low.
- CPRE: both column strobes are high again (column precharge).
- OPEN: the row is open and the block waits for the next request.
- PRECH: the row strobe is high and the row precharge time runs.

The transitions are:
- IDLE→ACTV when a request is accepted.
- ACTV→CSET when the row hold count expires.
- CSET→CACC after one cycle.
- CACC→CPRE when the column pulse count expires. Read data is captured on this edge.
- CPRE→OPEN when the column precharge count expires.
- OPEN→CSET on an accepted page hit.
- OPEN→PRECH on a page miss, or when the open-row limit is reached, provided the minimum row pulse width has been met.
- PRECH→IDLE when the precharge count expires.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is held and just after it, the row strobe, both column strobes, the write strobe and the output-enable strobe are high (all active low). The data drive enable is 0, the response valid is 0, and the block is ready for a request.
- R2: When the row strobe falls, the address bus carries the row, which is request address bits 19:8. When the column strobes fall, the bus carries the column, which is address bits 7:0 with the upper four bus bits zero.
- R3: Byte enable bit 0 drives the lower column strobe (data bits 7:0) and bit 1 drives the upper column strobe (bits 15:8). When both are selected they fall on the same edge; one strobe never falls while the other is already low. A byte enable of 00 is treated as 11.
- R4: A write is always an early write. The write strobe is low and the write data is driven from at least one cycle before the column strobes fall. The output-enable strobe stays high while the block drives data.
- R5: A read drives output enable low while the column strobes are low. The data is sampled on the edge that ends the column pulse. The response valid is high for exactly one cycle per read. Response lanes whose byte enable is clear read as zero.
- R6: A request whose row equals the open row is served without raising the row strobe, so no new row activation occurs.
- R7: A request to a different row raises the row strobe for at least the row precharge count (2 cycles at default) and then activates the new row.
- R8: Once it has fallen, the row strobe stays low for at least the minimum row pulse count (3 cycles at default).
- R9: When the open-row limit is reached, the row is closed even without a pending request. The next request to that row activates it again.
- R10: The column strobes are never low while the row strobe is high. Within one open row, both column strobes are high together for at least the column precharge count between accesses.
- R11: The ready output is high only when the block is idle, or when a row is open, the request hits it and the limit is not reached. It is never high while a column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 20 | Word address, row in 19:8, column in 7:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data, deselected lanes zero |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from memory |

## Verification
The hardest situation to reach from the ports is the forced close of an open row that has hit its time limit while no request is pending. The bench builds the controller with a short open-row limit of 50 cycles. It opens a row with a read and then presents no request for 60 cycles. It then checks that the row strobe has risen and that a request to the same row triggers a fresh activation. Page hits and misses are told apart by counting row strobe falls at the pins around each request. A memory model driven by the strobes stores the written bytes, so lane selection is checked through later full-word reads.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTV,
        ST_CSET,
        ST_CACC,
        ST_CPRE,
        ST_OPEN,
        ST_PRECH
    } edo_state_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_cyc_timer.sv
module edo_cyc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_page_trk.sv
module edo_page_trk #(
    parameter int ROW_W       = 12,
    parameter int CNT_W       = 13,
    parameter int RAS_MIN_CYC = 3,
    parameter int HOLD_LIMIT  = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_ld,
    input  logic [ROW_W-1:0] row_in,
    input  logic             ras_active,
    input  logic [ROW_W-1:0] req_row,
    output logic             page_hit,
    output logic             ras_min_ok,
    output logic             page_expired
);
    localparam logic [CNT_W-1:0] MIN_M1 = CNT_W'(RAS_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] LIM    = CNT_W'(HOLD_LIMIT);
    localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(HOLD_LIMIT - 1);

    logic [ROW_W-1:0] open_row_q;
    logic [CNT_W-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_row_q <= '0;
        end else if (row_ld) begin
            open_row_q <= row_in;
        end
    end

    // Cycles the row strobe has been low, saturating at the hold limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!ras_active) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q < LIM) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign page_hit     = ras_active && (req_row == open_row_q);
    assign ras_min_ok   = (low_cnt_q >= MIN_M1);
    assign page_expired = (low_cnt_q >= LIM_M1);
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int DQ_W      = 16,
    parameter int CLK_NS    = 20,
    parameter int T_RAH_NS  = 10,
    parameter int T_CAS_NS  = 10,
    parameter int T_CAC_NS  = 15,
    parameter int T_CP_NS   = 10,
    parameter int T_RP_NS   = 30,
    parameter int T_RAS_NS  = 50,
    parameter int T_RASP_NS = 100000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_we,
    input  logic [1:0]             req_be,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_data,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_ucas_n,
    output logic                   dram_lcas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);
    localparam int ADDR_W     = ROW_W + COL_W;
    localparam int LANE_W     = DQ_W / 2;
    localparam int RCD_CYC    = ns_to_cyc(T_RAH_NS, CLK_NS);
    localparam int CAS_CYC    = imax(ns_to_cyc(T_CAS_NS, CLK_NS), ns_to_cyc(T_CAC_NS, CLK_NS));
    localparam int CP_CYC     = ns_to_cyc(T_CP_NS, CLK_NS);
    localparam int RP_CYC     = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int RAS_CYC    = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RASP_CYC   = T_RASP_NS / CLK_NS;
    localparam int HOLD_LIMIT = RASP_CYC - (CAS_CYC + CP_CYC + 2);
    localparam int CNT_W      = $clog2(RASP_CYC + 1);
    localparam int TMR_W      = $clog2(RCD_CYC + CAS_CYC + CP_CYC + RP_CYC + 1);

    edo_state_t st_q, st_d;

    logic [ROW_W-1:0] lat_row_q;
    logic [COL_W-1:0] lat_col_q;
    logic             lat_we_q;
    logic [1:0]       lat_be_q;
    logic [DQ_W-1:0]  lat_wdata_q;

    logic             accept, capture, tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    logic             page_hit, ras_min_ok, page_expired, ras_active;

    edo_cyc_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_page_trk #(
        .ROW_W       (ROW_W),
        .CNT_W       (CNT_W),
        .RAS_MIN_CYC (RAS_CYC),
        .HOLD_LIMIT  (HOLD_LIMIT)
    ) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_ld       (accept && (st_q == ST_IDLE)),
        .row_in       (req_addr[ADDR_W-1:COL_W]),
        .ras_active   (ras_active),
        .req_row      (req_addr[ADDR_W-1:COL_W]),
        .page_hit     (page_hit),
        .ras_min_ok   (ras_min_ok),
        .page_expired (page_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state, timer loads and handshake
    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        req_ready = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept   = 1'b1;
                    st_d     = ST_ACTV;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RCD_CYC - 1);
                end
            end
            ST_ACTV: if (tmr_done) st_d = ST_CSET;
            ST_CSET: begin
                st_d     = ST_CACC;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CAS_CYC - 1);
            end
            ST_CACC: if (tmr_done) begin
                capture  = 1'b1;
                st_d     = ST_CPRE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CP_CYC - 1);
            end
            ST_CPRE: if (tmr_done) st_d = ST_OPEN;
            ST_OPEN: begin
                req_ready = page_hit && !page_expired;
                if (page_expired || (req_valid && !page_hit)) begin
                    if (ras_min_ok) begin
                        st_d     = ST_PRECH;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(RP_CYC - 1);
                    end
                end else if (req_valid) begin
                    accept = 1'b1;
                    st_d   = ST_CSET;
                end
            end
            ST_PRECH: if (tmr_done) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_row_q   <= '0;
            lat_col_q   <= '0;
            lat_we_q    <= 1'b0;
            lat_be_q    <= 2'b11;
            lat_wdata_q <= '0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
        end else begin
            if (accept) begin
                lat_row_q   <= req_addr[ADDR_W-1:COL_W];
                lat_col_q   <= req_addr[COL_W-1:0];
                lat_we_q    <= req_we;
                lat_be_q    <= (req_be == 2'b00) ? 2'b11 : req_be;
                lat_wdata_q <= req_wdata;
            end
            rsp_valid <= capture && !lat_we_q;
            if (capture && !lat_we_q) begin
                rsp_data <= dram_dq_in & {{LANE_W{lat_be_q[1]}}, {LANE_W{lat_be_q[0]}}};
            end
        end
    end

    // Strobe and bus outputs decoded from state
    always_comb begin
        ras_active  = (st_q inside {ST_ACTV, ST_CSET, ST_CACC, ST_CPRE, ST_OPEN});
        dram_ras_n  = !ras_active;
        dram_addr   = (st_q inside {ST_CSET, ST_CACC})
                      ? {{(ROW_W-COL_W){1'b0}}, lat_col_q} : lat_row_q;
        dram_lcas_n = !((st_q == ST_CACC) && lat_be_q[0]);
        dram_ucas_n = !((st_q == ST_CACC) && lat_be_q[1]);
        dram_we_n   = !((st_q inside {ST_CSET, ST_CACC}) && lat_we_q);
        dram_dq_oe  = (st_q inside {ST_CSET, ST_CACC}) && lat_we_q;
        dram_oe_n   = !((st_q == ST_CACC) && !lat_we_q);
        dram_dq_out = lat_wdata_q;
    end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int RP_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic dram_ras_n,
    input logic dram_ucas_n,
    input logic dram_lcas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    // R10
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras_n |-> (dram_ucas_n && dram_lcas_n));

    // R3
    no_stagger_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dram_ucas_n) && $past(dram_lcas_n)) |-> dram_lcas_n);

    // R3
    no_stagger_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dram_lcas_n) && $past(dram_ucas_n)) |-> dram_ucas_n);

    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_ucas_n) || $fell(dram_lcas_n)) && !dram_we_n) |-> !$past(dram_we_n));

    // R4
    bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    ready_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ucas_n && dram_lcas_n));

    generate
        if (RP_CYC >= 2) begin : g_rp
            // R7
            rp_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(dram_ras_n) |=> dram_ras_n);
        end
    endgenerate
endmodule

bind edo_ctrl edo_ctrl_chk #(.RP_CYC(RP_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .dram_ras_n  (dram_ras_n),
    .dram_ucas_n (dram_ucas_n),
    .dram_lcas_n (dram_lcas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_oe  (dram_dq_oe)
);

// File: tb/edo_ctrl_tb.sv
`timescale 1ns/1ps
module edo_ctrl_tb;
    localparam int RP_MIN  = 2;   // ceil(30/20)
    localparam int RAS_MIN = 3;   // ceil(50/20)
    localparam int CP_MIN  = 1;   // ceil(10/20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [11:0] dram_addr;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #10 clk = ~clk;

    edo_ctrl #(.T_RASP_NS(1000)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: 4 rows x 256 columns, driven only by the pins
    logic [15:0] mem [1024];
    logic [15:0] ref_mem [1024];
    logic [11:0] row_lat = '0;
    assign dram_dq_in = mem[{row_lat[1:0], dram_addr[7:0]}];

    // Scoreboard
    logic [15:0] exp_q [$];

    // Pin observations
    int          act_cnt = 0;
    logic [11:0] last_row = '0, last_col = '0;
    logic [1:0]  last_lanes = '0;
    logic        p_ras = 1'b1, p_cas = 1'b0, p_we = 1'b1, p_rsp = 1'b0;
    int          hi_len = 0, lo_len = 0, gap = 0;
    bit          seen_rise = 0, cas_in_row = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic cas_any;
            cas_any = !dram_ucas_n || !dram_lcas_n;
            if (p_ras && !dram_ras_n) begin
                act_cnt++;
                last_row = dram_addr;
                row_lat  = dram_addr;
                if (seen_rise) chk(hi_len >= RP_MIN, "R7 precharge width", hi_len, RP_MIN);
                cas_in_row = 0;
            end
            if (!p_ras && dram_ras_n) begin
                chk(lo_len >= RAS_MIN, "R8 row pulse width", lo_len, RAS_MIN);
                seen_rise = 1;
            end
            if (!p_cas && cas_any) begin
                last_col   = dram_addr;
                last_lanes = {!dram_ucas_n, !dram_lcas_n};
                chk(!dram_ras_n, "R10 column strobe under row strobe", dram_ras_n, 0);
                if (cas_in_row) chk(gap >= CP_MIN, "R10 column precharge", gap, CP_MIN);
                if (!dram_we_n) begin
                    chk(!p_we, "R4 write strobe before column strobe", p_we, 0);
                    chk(dram_oe_n && dram_dq_oe, "R4 output enable high, data driven",
                        {dram_oe_n, dram_dq_oe}, 2'b11);
                end
                cas_in_row = 1;
            end
            if (cas_any) begin
                chk(!req_ready, "R11 ready during column strobe", req_ready, 0);
                if (!dram_we_n && dram_dq_oe) begin
                    logic [15:0] w;
                    w = mem[{row_lat[1:0], dram_addr[7:0]}];
                    if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
                    if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
                    mem[{row_lat[1:0], dram_addr[7:0]}] = w;
                end
            end
            if (rsp_valid) begin
                chk(!p_rsp, "R5 single-cycle response", p_rsp, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected response", rsp_data, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R5 read data", rsp_data, e);
                end
            end
            hi_len = dram_ras_n ? (p_ras ? hi_len + 1 : 1) : 0;
            lo_len = !dram_ras_n ? (!p_ras ? lo_len + 1 : 1) : 0;
            gap    = (!dram_ras_n && !cas_any) ? gap + 1 : 0;
            p_ras  = dram_ras_n;
            p_cas  = cas_any;
            p_we   = dram_we_n;
            p_rsp  = rsp_valid;
        end
    end

    // Driver: pushes expected read data, updates the reference image
    task automatic issue(input logic [19:0] a, input bit w, input logic [1:0] be,
                         input logic [15:0] d, input bit expect_stall);
        logic [1:0]  beff;
        logic [9:0]  idx;
        logic [15:0] cur;
        beff = (be == 2'b00) ? 2'b11 : be;
        idx  = {a[9:8], a[7:0]};
        @(negedge clk);
        req_addr  = a;
        req_we    = w;
        req_be    = be;
        req_wdata = d;
        req_valid = 1'b1;
        if (w) begin
            cur = ref_mem[idx];
            if (beff[0]) cur[7:0]  = d[7:0];
            if (beff[1]) cur[15:8] = d[15:8];
            ref_mem[idx] = cur;
        end else begin
            exp_q.push_back(ref_mem[idx] & {{8{beff[1]}}, {8{beff[0]}}});
        end
        #1;
        if (expect_stall) chk(!req_ready, "R11 miss not accepted from open row", req_ready, 0);
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int a0;
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 16'h0000;
            ref_mem[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'b11111,
            "R1 strobes idle in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'b11111);
        chk(!dram_dq_oe && !rsp_valid, "R1 drive and response off", {dram_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && dram_ras_n, "R1 ready after reset", {req_ready, dram_ras_n}, 2'b11);

        // Full word write to row 1, column 0x10
        issue(20'h0_0110, 1'b1, 2'b11, 16'hA5A5, 1'b0);
        chk(act_cnt == 1, "R2 one activation", act_cnt, 1);
        chk(last_row == 12'h001, "R2 row on bus at row strobe", last_row, 12'h001);
        chk(last_col == 12'h010, "R2 column on bus at column strobe", last_col, 12'h010);
        chk(last_lanes == 2'b11, "R3 both lanes for full word", last_lanes, 2'b11);

        // Page hit read
        a0 = act_cnt;
        issue(20'h0_0110, 1'b0, 2'b11, 16'h0, 1'b0);
        chk(act_cnt == a0, "R6 page hit keeps row open", act_cnt, a0);

        // Upper byte only write (hit)
        issue(20'h0_0110, 1'b1, 2'b10, 16'h3C00, 1'b0);
        chk(last_lanes == 2'b10, "R3 upper lane only", last_lanes, 2'b10);
        // Lower byte read, upper lane must read zero
        issue(20'h0_0110, 1'b0, 2'b01, 16'h0, 1'b0);
        chk(last_lanes == 2'b01, "R3 lower lane only", last_lanes, 2'b01);
        // Byte enable 00 acts as full word
        issue(20'h0_0110, 1'b0, 2'b00, 16'h0, 1'b0);
        chk(last_lanes == 2'b11, "R3 enable 00 as full word", last_lanes, 2'b11);
        chk(act_cnt == a0, "R6 burst in one row", act_cnt, a0);

        // Page miss to row 2
        issue(20'h0_0220, 1'b1, 2'b11, 16'h1234, 1'b1);
        chk(act_cnt == a0 + 1, "R7 miss reactivates", act_cnt, a0 + 1);
        chk(last_row == 12'h002, "R7 new row on bus", last_row, 12'h002);
        issue(20'h0_0220, 1'b0, 2'b11, 16'h0, 1'b0);
        issue(20'h0_0110, 1'b0, 2'b11, 16'h0, 1'b1);
        chk(act_cnt == a0 + 2, "R7 miss back to row 1", act_cnt, a0 + 2);

        // Row left open beyond its limit
        repeat (60) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R9 row closed at limit", dram_ras_n, 1);
        chk(req_ready == 1'b1, "R11 idle ready", req_ready, 1);
        a0 = act_cnt;
        issue(20'h0_0110, 1'b0, 2'b11, 16'h0, 1'b0);
        chk(act_cnt == a0 + 1, "R9 reopen after limit", act_cnt, a0 + 1);

        // Lower byte write to a fresh location, then full read
        issue(20'h0_03FF, 1'b1, 2'b01, 16'hEE5A, 1'b0);
        issue(20'h0_03FF, 1'b0, 2'b11, 16'h0, 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
        finish_run();
    end
endmodule